// File: doc/BRIEF.md
# Double-Buffered Segmented Converter Input Register

This block is the digital front end of a 12-bit converter that sits on a microprocessor bus. The data word is split into three 4-bit input segments. Each segment is loaded from its own slice of a shared 12-bit data input. A segment takes data only while the active-low chip select is asserted together with that segment's enable, so a 4-, 8- or 16-bit bus can assemble a full word over one or more writes. A separate load strobe then copies all three segments at once into a 12-bit holding register. Only the holding register sets the output code, so the input segments can be rewritten freely without disturbing the output.

All strobes act on their level. A latch follows its data while its strobe is open and freezes when the strobe closes. In this model the strobe levels are sampled on a system clock. When a segment strobe and the load strobe are open in the same cycle, new data passes through both ranks at that clock edge.

The registered output gives a 12-bit code and a 13-bit signed level. A mode input selects the interpretation: straight binary, complementary binary or bipolar offset binary. Each strobe has a minimum width, set by a parameter in clock cycles. A strobe pulse shorter than this sets a sticky timing-error flag, but the pulse still updates its latch.

Top module: `dac_dbuf_front`

## Requirements
- R1: While `rst_n` is low at a clock edge, the edge clears all three segments, the holding register, `code_out`, `level_out` and `timing_err` to zero.
- R2: Segment writes are gated and mapped as follows:
  - Segment 0 (`seg_en[0]`) takes `din[3:0]`, the least significant end of the word.
  - Segment 1 (`seg_en[1]`) takes `din[7:4]`.
  - Segment 2 (`seg_en[2]`) takes `din[11:8]`, the most significant end.
  - A segment changes only at an edge where `cs_n` is 0 and its enable is 1. Otherwise it keeps its value.
- R3: Any set of segment enables may be asserted at the same time. Every enabled segment loads at the same edge.
- R4: While a segment's strobe stays open, the segment takes the current `din` slice at every edge. After the strobe closes, it keeps the last value taken.
- R5: While `load` is 1, the holding register takes the input rank at every edge. While `load` is 0, it keeps its value, however the segments are rewritten.
- R6: The holding register always takes the next value of the input rank. When `load` and a segment strobe are open at the same edge, the holding register receives that edge's `din` slice.
- R7: `mode` sets the output interpretation:
  - Mode 1: `code_out` is the bitwise inverse of the holding register.
  - Mode 2: `code_out` is the holding register, and `level_out` is the holding register minus 2048 (signed).
  - Modes 0 and 3: `code_out` is the holding register.
  - In modes 0, 1 and 3, `level_out` is `code_out` zero-extended.
- R8: `code_out` and `level_out` are registered. They reflect the holding register and `mode` one clock edge after the holding register changes.
- R9: A segment strobe (`cs_n` low with that segment's enable) or a `load` pulse that is high for fewer than `MIN_STROBE_CYC` consecutive edges sets `timing_err` at the edge where it is first seen low. The pulse still updates its latch.
- R10: Strobe pulses of at least `MIN_STROBE_CYC` edges leave `timing_err` at 0.
- R11: Once set, `timing_err` stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Active-low chip select |
| seg_en | input | 3 | Per-segment write enables; bit 0 is the least significant segment |
| load | input | 1 | Level strobe copying the input rank into the holding register |
| din | input | 12 | Shared data input |
| mode | input | 2 | 0 binary, 1 complementary binary, 2 bipolar offset binary, 3 binary |
| code_out | output | 12 | Registered output code |
| level_out | output | 13 | Registered signed level; relative to mid-scale in mode 2 |
| timing_err | output | 1 | Sticky flag for a strobe pulse shorter than the minimum width |

## Verification
Assertions check every cycle that:
- each segment holds while its strobe is closed and follows `din` while it is open;
- the holding register keeps its value without `load` and takes the next input-rank value with it;
- complementary and bipolar outputs track the previous holding value;
- the error flag is set after any short pulse and never clears while out of reset.

Other behaviours can only be shown by the bench's scenarios:
- which `din` slice lands in which segment;
- the full 4096-code sweep in all three modes;
- the one-edge output latency while both ranks are transparent;
- the exact boundary between a short pulse and a legal one.

// File: rtl/dacfe_pkg.sv
// Shared definitions for the double-buffered converter front end.
// Assumes a two-bit mode field; the unused encoding is treated as binary.
package dacfe_pkg;

    typedef enum logic [1:0] {
        MODE_BIN  = 2'd0,
        MODE_CBIN = 2'd1,
        MODE_OBIN = 2'd2,
        MODE_RSVD = 2'd3
    } code_mode_e;

endpackage

// File: rtl/seg_latch.sv
// One input segment of the first rank: a level latch modelled on the clock.
// While wr_i is high the segment takes d_i at every edge; otherwise it holds.
// nxt_o exposes the value the segment will hold after the coming edge, so a
// transparent second rank can pass data through in the same cycle.
// Assumes a synchronous active-low reset.
module seg_latch #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_i,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] nxt_o
);

    logic [W-1:0] q;

    // Next segment value: data while open, stored value while closed.
    always_comb begin
        nxt_o = wr_i ? d_i : q;
    end

    // Segment storage.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= nxt_o;
    end

    AST_SEG_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_i |=> $stable(q)); // R2

    AST_SEG_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |=> (q == $past(d_i))); // R4

endmodule

// File: rtl/strobe_mon.sv
// Pulse-width monitor for one level strobe.
// Counts consecutive high edges (saturating at MIN_CYC) and flags, while the
// strobe is sampled low just after a pulse, that the pulse was too short.
// Assumes MIN_CYC >= 1; with MIN_CYC == 1 no pulse can be short.
module strobe_mon #(
    parameter int MIN_CYC = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_i,
    output logic short_o
);

    localparam int CW = $clog2(MIN_CYC + 1);
    localparam logic [CW-1:0] MIN_V = CW'(MIN_CYC);

    logic [CW-1:0] cnt;

    // High-time counter: saturates at the minimum, clears when low.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (!lvl_i)     cnt <= '0;
        else if (cnt < MIN_V) cnt <= cnt + 1'b1;
    end

    // Short pulse: strobe just closed after fewer than the minimum edges.
    always_comb begin
        short_o = !lvl_i && (cnt != '0) && (cnt < MIN_V);
    end

endmodule

// File: rtl/hold_reg.sv
// Second-rank holding register. Follows the input rank while load_i is high
// and keeps its contents while it is low. d_i is the input rank's next value.
// Assumes a synchronous active-low reset.
module hold_reg #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    // Holding register update.
    always_ff @(posedge clk) begin
        if (!rst_n)      q_o <= '0;
        else if (load_i) q_o <= d_i;
    end

    AST_HOLD_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> $stable(q_o)); // R5

    AST_HOLD_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (q_o == $past(d_i))); // R6

endmodule

// File: rtl/code_map.sv
// Output stage: maps the holding register to a registered output code and a
// signed level according to the selected interpretation.
// Assumes the reserved mode encoding behaves as straight binary.
module code_map
    import dacfe_pkg::*;
#(
    parameter int W = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [1:0]          mode_i,
    input  logic [W-1:0]        hold_i,
    output logic [W-1:0]        code_o,
    output logic signed [W:0]   level_o
);

    localparam logic [W:0] MID = (W+1)'(1) << (W-1);

    logic [W-1:0] code_n;
    logic [W:0]   level_n;

    // Combinational mapping of the held word.
    always_comb begin
        code_n  = hold_i;
        level_n = {1'b0, hold_i};
        case (code_mode_e'(mode_i))
            MODE_CBIN: begin
                code_n  = ~hold_i;
                level_n = {1'b0, ~hold_i};
            end
            MODE_OBIN: begin
                level_n = {1'b0, hold_i} - MID;
            end
            default: ;
        endcase
    end

    // Output registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_o  <= '0;
            level_o <= '0;
        end else begin
            code_o  <= code_n;
            level_o <= $signed(level_n);
        end
    end

    AST_CMAP_COMP: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == MODE_CBIN) |=> (code_o == ~$past(hold_i))); // R7

    AST_CMAP_BIPOLAR: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == MODE_OBIN) |=>
            (level_o == ($signed({1'b0, $past(hold_i)}) - $signed(MID)))); // R7

endmodule

// File: rtl/dac_dbuf_front.sv
// Double-buffered segmented input register for a 12-bit converter.
// N_SEG input segments of SEG_W bits are written under an active-low chip
// select and per-segment enables; a level load strobe copies them into the
// holding register, which alone drives the mapped output. Every strobe is
// width-checked against MIN_STROBE_CYC and a short pulse sets a sticky flag.
// Assumes level strobes are synchronous to clk and a synchronous active-low reset.
module dac_dbuf_front
    import dacfe_pkg::*;
#(
    parameter int SEG_W          = 4,
    parameter int N_SEG          = 3,
    parameter int MIN_STROBE_CYC = 3,
    localparam int CODE_W        = SEG_W * N_SEG
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cs_n,
    input  logic [N_SEG-1:0]         seg_en,
    input  logic                     load,
    input  logic [CODE_W-1:0]        din,
    input  logic [1:0]               mode,
    output logic [CODE_W-1:0]        code_out,
    output logic signed [CODE_W:0]   level_out,
    output logic                     timing_err
);

    logic [N_SEG-1:0]  seg_wr;
    logic [CODE_W-1:0] seg_nxt;
    logic [CODE_W-1:0] hold_q;
    logic [N_SEG:0]    short_v;

    // First rank: one latch and one width monitor per segment.
    for (genvar g = 0; g < N_SEG; g++) begin : g_seg
        assign seg_wr[g] = ~cs_n & seg_en[g];

        seg_latch #(.W(SEG_W)) u_lat (
            .clk   (clk),
            .rst_n (rst_n),
            .wr_i  (seg_wr[g]),
            .d_i   (din[g*SEG_W +: SEG_W]),
            .nxt_o (seg_nxt[g*SEG_W +: SEG_W])
        );

        strobe_mon #(.MIN_CYC(MIN_STROBE_CYC)) u_mon (
            .clk     (clk),
            .rst_n   (rst_n),
            .lvl_i   (seg_wr[g]),
            .short_o (short_v[g])
        );
    end

    strobe_mon #(.MIN_CYC(MIN_STROBE_CYC)) u_load_mon (
        .clk     (clk),
        .rst_n   (rst_n),
        .lvl_i   (load),
        .short_o (short_v[N_SEG])
    );

    hold_reg #(.W(CODE_W)) u_hold (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (load),
        .d_i    (seg_nxt),
        .q_o    (hold_q)
    );

    code_map #(.W(CODE_W)) u_map (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode_i  (mode),
        .hold_i  (hold_q),
        .code_o  (code_out),
        .level_o (level_out)
    );

    // Sticky timing-error flag.
    always_ff @(posedge clk) begin
        if (!rst_n) timing_err <= 1'b0;
        else        timing_err <= timing_err | (|short_v);
    end

    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (code_out == '0 && level_out == '0 && !timing_err)); // R1

    AST_SHORT_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (|short_v) |=> timing_err); // R9

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        timing_err |=> timing_err); // R11

endmodule

// File: tb/dac_dbuf_front_test.sv
module dac_dbuf_front_test;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               cs_n = 1'b1;
    logic [2:0]         seg_en = 3'b000;
    logic               load = 1'b0;
    logic [11:0]        din = 12'h000;
    logic [1:0]         mode = 2'd0;
    logic [11:0]        code_out;
    logic signed [12:0] level_out;
    logic               timing_err;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    dac_dbuf_front uut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .seg_en(seg_en), .load(load),
        .din(din), .mode(mode), .code_out(code_out), .level_out(level_out),
        .timing_err(timing_err)
    );

    always #10 clk = ~clk;

    function automatic logic [11:0] exp_code(logic [11:0] h, int m);
        return (m == 1) ? ~h : h;
    endfunction

    function automatic logic signed [12:0] exp_level(logic [11:0] h, int m);
        if (m == 2) return $signed({1'b0, h}) - 13'sd2048;
        return $signed({1'b0, exp_code(h, m)});
    endfunction

    task automatic chk_out(string req, logic [11:0] h, int m);
        n_chk++;
        if (code_out !== exp_code(h, m) || level_out !== exp_level(h, m)) begin
            n_fail++;
            $display("FAIL %s: code=%h level=%0d expected code=%h level=%0d",
                     req, code_out, level_out, exp_code(h, m), exp_level(h, m));
        end
    endtask

    task automatic chk_err(string req, logic e);
        n_chk++;
        if (timing_err !== e) begin
            n_fail++;
            $display("FAIL %s: timing_err=%b expected %b", req, timing_err, e);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; cs_n = 1'b1; seg_en = '0; load = 1'b0;
        tick(); tick();
        rst_n = 1'b1;
    endtask

    task automatic wr_seg(logic [2:0] en, logic [11:0] d, int n);
        cs_n = 1'b0; seg_en = en; din = d;
        repeat (n) tick();
        cs_n = 1'b1; seg_en = '0;
    endtask

    task automatic pulse_load(int n);
        load = 1'b1;
        repeat (n) tick();
        load = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: run did not end, actual timeout expected completion");
        finish_run();
    end

    initial begin
        @(negedge clk);
        do_reset();
        // R1: reset state
        chk_out("R1", 12'h000, 0);
        chk_err("R1", 1'b0);

        // R6/R7: sweep every code through both ranks at once, all three modes
        for (int v = 0; v < 4096; v++) begin
            cs_n = 1'b0; seg_en = 3'b111; load = 1'b1; din = 12'(v);
            repeat (3) tick();
            cs_n = 1'b1; seg_en = '0; load = 1'b0;
            for (int m = 0; m < 3; m++) begin
                mode = 2'(m);
                tick();
                chk_out("R6 R7 sweep", 12'(v), m);
            end
        end
        mode = 2'd3; tick();
        chk_out("R7 mode3", 12'hFFF, 0);
        mode = 2'd0;

        // R3: all segments loaded together
        wr_seg(3'b111, 12'h000, 3); pulse_load(3); tick();
        chk_out("R3", 12'h000, 0);

        // R2: segment to slice mapping
        wr_seg(3'b001, 12'h5A7, 3); pulse_load(3); tick();
        chk_out("R2 seg0", 12'h007, 0);
        wr_seg(3'b010, 12'h3C9, 3); pulse_load(3); tick();
        chk_out("R2 seg1", 12'h0C7, 0);
        wr_seg(3'b100, 12'hE12, 3); pulse_load(3); tick();
        chk_out("R2 seg2", 12'hEC7, 0);

        // R2: writes without chip select or without enable are ignored
        cs_n = 1'b1; seg_en = 3'b111; din = 12'h123;
        repeat (3) tick();
        seg_en = '0; cs_n = 1'b0; din = 12'h456;
        repeat (3) tick();
        cs_n = 1'b1;
        pulse_load(3); tick();
        chk_out("R2 gated", 12'hEC7, 0);

        // R4: transparent while open, frozen after close
        cs_n = 1'b0; seg_en = 3'b001;
        for (int k = 1; k <= 4; k++) begin
            din = 12'(k);
            tick();
        end
        cs_n = 1'b1; seg_en = '0; din = 12'h009;
        tick(); din = 12'h00B; tick();
        pulse_load(3); tick();
        chk_out("R4", 12'hEC4, 0);

        // R5: rewriting segments does not disturb held output
        wr_seg(3'b111, 12'h111, 3);
        tick();
        chk_out("R5 hold", 12'hEC4, 0);
        pulse_load(3); tick();
        chk_out("R5 update", 12'h111, 0);

        // R8: one-edge output latency with both ranks open
        cs_n = 1'b0; seg_en = 3'b111; load = 1'b1; din = 12'h0F0;
        repeat (3) tick();
        chk_out("R8 settled", 12'h0F0, 0);
        din = 12'h321;
        tick();
        chk_out("R8 latency", 12'h0F0, 0);
        tick();
        chk_out("R8 update", 12'h321, 0);
        cs_n = 1'b1; seg_en = '0; load = 1'b0;
        tick();

        // R10: all pulses so far met the minimum width
        chk_err("R10", 1'b0);

        // R9: short load pulse flags but still updates
        wr_seg(3'b111, 12'hA5A, 3);
        pulse_load(1); tick();
        chk_err("R9 load", 1'b1);
        chk_out("R9 load update", 12'hA5A, 0);

        // R11: flag stays set
        repeat (5) tick();
        chk_err("R11", 1'b1);
        do_reset();
        chk_err("R11 reset", 1'b0);

        // R9: short segment strobe flags but still loads
        wr_seg(3'b010, 12'h070, 1); tick();
        chk_err("R9 seg", 1'b1);
        pulse_load(3); tick();
        chk_out("R9 seg update", 12'h070, 0);

        // R10: pulse of exactly the minimum after reset does not flag
        do_reset();
        wr_seg(3'b100, 12'h800, 3); pulse_load(3); tick();
        chk_err("R10 boundary", 1'b0);
        mode = 2'd2; tick();
        chk_out("R7 midscale", 12'h800, 2);

        finish_run();
    end

endmodule